// File: doc/BRIEF.md
# Fetch Address Sequencer with Branch Delay Slot

This block produces the instruction fetch address for a 32-bit core. Every instruction is one 32-bit word, and each taken branch or jump is followed by one delay-slot instruction that always runs. Each cycle the decode stage presents the control bits for the instruction at the current address. It also supplies the two register operands to compare, the 16-bit branch displacement, the 26-bit jump field and a register-held target.

The block always fetches the word after a resolved transfer first, because that word is the delay slot. It holds the target in one pending register and loads that target into the fetch address on the next advance. A flag marks a fetch address whose two low bits are not zero. A second flag marks a control-transfer instruction that sits inside a delay slot. Such an instruction never replaces the transfer that is already pending.

Top module: `fetch_addr_seq`

## Requirements
- R1: While `rst_n` is low, `pc_q` loads `RESET_VEC` (default 32'hBFC0_0000) and any pending transfer is dropped. After release, `next_pc` is `RESET_VEC + 4` and both flags are low.
- R2: With no transfer pending and no taken transfer in decode, each cycle with `adv` high moves `pc_q` to `pc_q + 4`.
- R3: `take_eq` is taken when `src_a == src_b`, and `take_ne` is taken when they differ. The target is `pc_q + 4` plus the 16-bit displacement, sign-extended and multiplied by 4.
- R4: The target of `jmp_abs` is the top 4 bits of `pc_q`, then the 26-bit `jmp_field`, then two zero bits.
- R5: The target of `jmp_reg` is the 32-bit value on `jmp_addr`.
- R6: After a taken transfer is accepted, the next fetch is `pc_q + 4` (the delay slot). The fetch after that is the target. A branch that is not taken causes no redirect.
- R7: `misalign` is high exactly when either of the two low bits of `next_pc` is 1.
- R8: Any control bit raised while the decoded instruction sits in a delay slot sets `slot_fault`. It leaves the pending target unchanged and does not arm a new one.
- R9: While `adv` is low, `pc_q` and the pending transfer hold their values.
- R10: When several control bits are high together, the winner is chosen in this order: `jmp_reg`, then `jmp_abs`, then `take_eq`, then `take_ne`. Only the winner decides whether a transfer is taken and where it goes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Fetch advance; the decoded instruction is accepted |
| take_eq | input | 1 | Branch if the operands are equal |
| take_ne | input | 1 | Branch if the operands differ |
| jmp_abs | input | 1 | Region-relative absolute jump |
| jmp_reg | input | 1 | Jump to a register-held address |
| src_a | input | 32 | First compared operand |
| src_b | input | 32 | Second compared operand |
| br_disp | input | 16 | Branch displacement in words |
| jmp_field | input | 26 | Absolute jump word index |
| jmp_addr | input | 32 | Register jump target |
| pc_q | output | 32 | Address of the instruction in decode |
| next_pc | output | 32 | Address of the next fetch |
| misalign | output | 1 | `next_pc` is not word aligned |
| slot_fault | output | 1 | Control transfer found inside a delay slot |

## Verification
Both branch kinds are swept over pairs of equal and unequal operands. The unequal pairs differ in a single bit at the low end, in the middle and in the sign bit, which separates a full 32-bit compare from a partial one and shows which kind is taken. Displacements cover zero, ±1, ±2 and both 16-bit extremes, which exposes a missing sign extension, a missing shift by two and a wrong base address. Absolute jumps are tried with all-zero, all-one and alternating fields, including one launched from the last word of a 256 MB region, to show which address supplies the upper bits. Register jumps are tried with every low-bit pattern to exercise the alignment flag. Transfers placed in delay slots, simultaneous control bits and stalled cycles check the guard, the priority order and the hold behaviour.

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq #(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        take_eq,
  input  logic        take_ne,
  input  logic        jmp_abs,
  input  logic        jmp_reg,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [15:0] br_disp,
  input  logic [25:0] jmp_field,
  input  logic [31:0] jmp_addr,
  output logic [31:0] pc_q,
  output logic [31:0] next_pc,
  output logic        misalign,
  output logic        slot_fault
);
  logic [31:0] pend_tgt;
  logic        pend_v;
  logic [31:0] seq_pc, br_tgt, abs_tgt, sel_tgt;
  logic        same, any_ctl, taken, launch;

  assign seq_pc  = pc_q + 32'd4;
  assign br_tgt  = seq_pc + {{14{br_disp[15]}}, br_disp, 2'b00};
  assign abs_tgt = {pc_q[31:28], jmp_field, 2'b00};
  assign same    = (src_a == src_b);
  assign any_ctl = take_eq | take_ne | jmp_abs | jmp_reg;

  always_comb begin
    taken   = 1'b0;
    sel_tgt = br_tgt;
    if (jmp_reg) begin
      taken   = 1'b1;
      sel_tgt = jmp_addr;
    end else if (jmp_abs) begin
      taken   = 1'b1;
      sel_tgt = abs_tgt;
    end else if (take_eq) begin
      taken   = same;
    end else if (take_ne) begin
      taken   = ~same;
    end
  end

  assign launch     = taken & ~pend_v;
  assign slot_fault = any_ctl & pend_v;
  assign next_pc    = pend_v ? pend_tgt : seq_pc;
  assign misalign   = |next_pc[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_VEC;
      pend_v   <= 1'b0;
      pend_tgt <= '0;
    end else if (adv) begin
      pc_q <= next_pc;
      if (pend_v) begin
        pend_v <= 1'b0;
      end else if (launch) begin
        pend_v   <= 1'b1;
        pend_tgt <= sel_tgt;
      end
    end
  end
endmodule

// File: rtl/fetch_addr_seq_chk.sv
module fetch_addr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adv,
  input logic [31:0] pc_q,
  input logic        misalign,
  input logic        slot_fault,
  input logic        pend_v,
  input logic [31:0] pend_tgt,
  input logic        launch
);
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !pend_v && !launch |=> pc_q == $past(pc_q) + 32'd4 && !pend_v); // R2
  AST_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    adv && launch |=> pend_v && pc_q == $past(pc_q) + 32'd4); // R6
  AST_TARGET_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    adv && pend_v |=> !pend_v && pc_q == $past(pend_tgt)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc_q) && $stable(pend_v) && $stable(pend_tgt)); // R9
  AST_FAULT_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fault |-> pend_v && !launch); // R8
  AST_MISALIGN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    adv && misalign |=> pc_q[1:0] != 2'b00); // R7
endmodule

bind fetch_addr_seq fetch_addr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .pc_q(pc_q), .misalign(misalign),
  .slot_fault(slot_fault), .pend_v(pend_v), .pend_tgt(pend_tgt), .launch(launch)
);

// File: tb/tb_fetch_addr_seq.sv
module tb_fetch_addr_seq;
  localparam logic [31:0] VEC = 32'hBFC0_0000;
  logic clk = 1'b0, rst_n = 1'b0, adv = 1'b0;
  logic t_eq = 1'b0, t_ne = 1'b0, j_abs = 1'b0, j_reg = 1'b0;
  logic [31:0] a = '0, b = '0, jaddr = '0;
  logic [15:0] disp = '0;
  logic [25:0] jfld = '0;
  logic [31:0] pc_q, next_pc;
  logic misalign, slot_fault;
  int checks = 0, errors = 0;
  logic [31:0] m_pc, m_pt;
  logic m_pv;

  always #5 clk = ~clk;

  fetch_addr_seq #(.RESET_VEC(VEC)) dut (
    .clk(clk), .rst_n(rst_n), .adv(adv), .take_eq(t_eq), .take_ne(t_ne),
    .jmp_abs(j_abs), .jmp_reg(j_reg), .src_a(a), .src_b(b), .br_disp(disp),
    .jmp_field(jfld), .jmp_addr(jaddr), .pc_q(pc_q), .next_pc(next_pc),
    .misalign(misalign), .slot_fault(slot_fault));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic e, input logic n, input logic ja, input logic jr,
                       input logic [31:0] va, input logic [31:0] vb, input logic [15:0] d,
                       input logic [25:0] f, input logic [31:0] ra);
    logic tk, ctl;
    logic [31:0] tgt, exp_next;
    @(negedge clk);
    t_eq = e; t_ne = n; j_abs = ja; j_reg = jr;
    a = va; b = vb; disp = d; jfld = f; jaddr = ra; adv = 1'b1;
    #1;
    ctl = e | n | ja | jr;
    tk = 1'b0;
    tgt = m_pc + 32'd4 + {{14{d[15]}}, d, 2'b00};
    if (jr) begin tk = 1'b1; tgt = ra; end
    else if (ja) begin tk = 1'b1; tgt = {m_pc[31:28], f, 2'b00}; end
    else if (e) tk = (va == vb);
    else if (n) tk = (va != vb);
    exp_next = m_pv ? m_pt : m_pc + 32'd4;
    chk(req, "pc_q", pc_q, m_pc);
    chk(req, "next_pc", next_pc, exp_next);
    chk("R7", "misalign", {31'd0, misalign}, {31'd0, |exp_next[1:0]});
    chk("R8", "slot_fault", {31'd0, slot_fault}, {31'd0, ctl & m_pv});
    if (m_pv) m_pv = 1'b0;
    else if (tk) begin m_pv = 1'b1; m_pt = tgt; end
    m_pc = exp_next;
  endtask

  task automatic nop(input string req);
    issue(req, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
  endtask

  task automatic stall_check();
    @(negedge clk);
    adv = 1'b0; t_eq = 1'b0; t_ne = 1'b0; j_abs = 1'b0; j_reg = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "pc_q during stall", pc_q, m_pc);
    chk("R9", "next_pc during stall", next_pc, m_pv ? m_pt : m_pc + 32'd4);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] disps [8];
    logic [25:0] flds [5];
    disps = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF, 16'hFFFE, 16'h7FFF, 16'h8000, 16'h0100};
    flds  = '{26'h0000000, 26'h0000001, 26'h3FFFFFF, 26'h1555555, 26'h2AAAAAA};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "pc_q after reset", pc_q, VEC);
    chk("R1", "next_pc after reset", next_pc, VEC + 32'd4);
    chk("R1", "flags after reset", {30'd0, misalign, slot_fault}, 32'd0);
    m_pc = VEC; m_pv = 1'b0; m_pt = '0;
    for (int i = 0; i < 4; i++) nop("R2");
    // R3 R6 branch sweep
    for (int k = 0; k < 2; k++)
      for (int di = 0; di < 8; di++)
        for (int bit_sel = 0; bit_sel < 4; bit_sel++) begin
          logic [31:0] va, vb;
          va = 32'h1234_5678 + 32'(di * 977);
          vb = (bit_sel == 0) ? va : va ^ (32'd1 << (bit_sel == 1 ? 0 : (bit_sel == 2 ? 15 : 31)));
          issue("R3", k == 0, k == 1, 1'b0, 1'b0, va, vb, disps[di], '0, '0);
          nop("R6");
          nop("R6");
        end
    // R4 absolute jumps, including from the last word of a region
    for (int fi = 0; fi < 5; fi++) begin
      issue("R4", 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, flds[fi], '0);
      nop("R6");
      nop("R4");
    end
    issue("R5", 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0, '0, 32'h2FFF_FFFC);
    nop("R6");
    issue("R4", 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, 26'h0000040, '0);
    nop("R6");
    nop("R4");
    // R5 R7 register jumps with every low-bit pattern
    for (int lb = 0; lb < 4; lb++) begin
      issue("R5", 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0, '0, 32'h8000_0010 + 32'(lb));
      nop("R7");
      nop("R7");
      issue("R5", 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0, '0, 32'h0040_0000);
      nop("R6");
    end
    // R8 transfers placed in delay slots
    issue("R3", 1'b1, 1'b0, 1'b0, 1'b0, 32'd5, 32'd5, 16'h0008, '0, '0);
    issue("R8", 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, 26'h3000000, '0);
    nop("R8");
    nop("R8");
    issue("R5", 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0, '0, 32'h0000_1000);
    issue("R8", 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0, '0, 32'h0000_9000);
    nop("R8");
    issue("R4", 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, 26'h0000800, '0);
    issue("R8", 1'b0, 1'b1, 1'b0, 1'b0, 32'd1, 32'd1, 16'h0040, '0, '0);
    nop("R8");
    // R10 priority among simultaneous control bits
    issue("R10", 1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, 26'h0000100, 32'h0000_7000);
    nop("R10");
    issue("R10", 1'b1, 1'b0, 1'b1, 1'b0, 32'd1, 32'd2, 16'h0010, 26'h0000200, '0);
    nop("R10");
    issue("R10", 1'b1, 1'b1, 1'b0, 1'b0, 32'd3, 32'd3, 16'h0004, '0, '0);
    nop("R10");
    issue("R10", 1'b1, 1'b1, 1'b0, 1'b0, 32'd3, 32'd4, 16'h0004, '0, '0);
    nop("R10");
    // R9 stalls, with and without a pending transfer
    stall_check();
    issue("R4", 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, 26'h0000300, '0);
    stall_check();
    nop("R9");
    nop("R9");
    @(negedge clk);
    adv = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule